// File: doc/BRIEF.md
# Eight-Channel Memory Transfer Engine

This block performs individual moves for an eight-channel DMA controller. Each channel stores a source address, a destination address, a remaining-transfer count and a five-bit mode word. A pulse on a channel's trigger line requests one step on that channel. A step reads one item from the source and writes it to the destination over a simple byte-addressed memory bus. It then adjusts either or both addresses by the item size and lowers the count by one. When the count reaches zero, the step raises that channel's terminal-count pulse.

A counter mode moves no data. In that mode a step only adds one to the source register and lowers the count, so the channel can count events. Software-side logic programs the registers through a single write port.

Triggers that arrive while a step is running are remembered, one per channel. They are taken lowest channel number first once the engine is free. A mode word with a reserved encoding is refused, and the refusal is reported on an error pulse.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `busy`, `err`, `tc_irq`, `mem_rd` and `mem_wr` are all low, and no bus access takes place until a trigger arrives.
- R2: Mode word bits [4:2] = 000 read from a fixed source and write the destination, then step the destination up by the item size. Value 001 behaves the same but steps the destination down.
- R3: Mode value 010 reads the source and writes a fixed destination, then steps the source up. Value 011 behaves the same but steps the source down.
- R4: Mode value 100 steps both addresses up after the move. Value 101 steps both addresses down.
- R5: Mode value 110 moves data with both addresses left unchanged.
- R6: Mode value 111 with size 00 is a counter step: it makes no bus access, adds 1 to the source register and lowers the count by one.
- R7: Mode word bits [1:0] give the item size: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. `mem_size` carries this code during the access. The written word holds exactly those low bytes of the read word (little-endian), with the upper bytes zero. Every address step in modes 000 to 101 equals that byte count.
- R8: Every accepted step lowers the channel's count by one. When the new count is zero, `tc_irq[n]` is high for exactly one cycle, namely the first cycle in which `busy` is low again.
- R9: A trigger sampled at clock edge k starts a step at edge k+1 when the engine is idle. `busy` then stays high for 6 cycles in modes 100 and 101 and for 5 cycles in every other mode.
- R10: A trigger on a channel whose size is 11, or whose mode is 111 with a size other than 00, causes no bus access and changes no register. `busy` stays low, and `err` pulses high for one cycle at the edge where the step would have started.
- R11: A trigger that arrives while the engine is busy is held as one pending request per channel; repeated triggers on the same channel merge into one. Pending requests are started lowest channel number first, one idle cycle after each step ends.
- R12: Within a data-moving step, `mem_rd` is high in the 2nd busy cycle with `mem_addr` equal to the source. `mem_wr` is high in the 4th busy cycle with `mem_addr` equal to the destination and `mem_wdata` holding the data returned one cycle after the read.
- R13: A configuration write with `cfg_sel` 0, 1, 2 or 3 loads the source, destination, count or mode word (mode taken from `cfg_wdata[4:0]`) of channel `cfg_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W (3) | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 mode |
| cfg_wdata | input | ADDR_W (24) | Write data |
| trig | input | NUM_CH (8) | One-cycle step request per channel |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W (24) | Byte address of the access |
| mem_size | output | 2 | Item size code of the access |
| mem_wdata | output | DATA_W (32) | Write data |
| mem_rdata | input | DATA_W (32) | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | High while a step is running |
| tc_irq | output | NUM_CH (8) | One-cycle terminal-count pulse per channel |
| err | output | 1 | One-cycle pulse on a refused mode word |

## Verification
Counting from the edge that samples a trigger, the step starts one edge later. The read strobe falls in the second busy cycle and the write strobe in the fourth. After five or six busy cycles, the terminal-count pulse appears in the first cycle with `busy` low. An error pulse appears one edge after the sampling edge with `busy` never rising. The bench samples at falling edges. It numbers the busy cycles it sees, so every strobe, address, data word and pulse is compared in the exact cycle it is due. Updated addresses and counts are not visible at the ports, so the bench observes them through the next step's bus addresses and terminal-count pulse.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

   typedef enum logic [2:0] {
      M_DST_UP   = 3'd0,
      M_DST_DN   = 3'd1,
      M_SRC_UP   = 3'd2,
      M_SRC_DN   = 3'd3,
      M_BOTH_UP  = 3'd4,
      M_BOTH_DN  = 3'd5,
      M_HOLD     = 3'd6,
      M_TALLY    = 3'd7
   } xfer_mode_e;

   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_DST  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_MODE = 2'd3
   } cfg_sel_e;

   // step lengths in busy cycles
   localparam int LEN_SHORT = 5;
   localparam int LEN_LONG  = 6;
   // position of bus phases inside a step
   localparam int PH_READ  = 1;
   localparam int PH_LATCH = 2;
   localparam int PH_WRITE = 3;

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      case (sz)
         2'b00:   size_bytes = 3'd1;
         2'b01:   size_bytes = 3'd2;
         2'b10:   size_bytes = 3'd4;
         default: size_bytes = 3'd0;
      endcase
   endfunction

   function automatic logic mode_ok(input logic [4:0] m);
      mode_ok = (m[1:0] != 2'b11) && !((m[4:2] == 3'(M_TALLY)) && (m[1:0] != 2'b00));
   endfunction

   function automatic logic is_long(input logic [4:0] m);
      is_long = (m[4:2] == 3'(M_BOTH_UP)) || (m[4:2] == 3'(M_BOTH_DN));
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_eng_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              upd_en,
   input  logic [CH_W-1:0]   upd_ch,
   input  logic [ADDR_W-1:0] upd_src,
   input  logic [ADDR_W-1:0] upd_dst,
   input  logic [CNT_W-1:0]  upd_cnt,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [ADDR_W-1:0] rd_src,
   output logic [ADDR_W-1:0] rd_dst,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic [4:0]        rd_mode
);

   logic [ADDR_W-1:0] src_q  [NUM_CH];
   logic [ADDR_W-1:0] dst_q  [NUM_CH];
   logic [CNT_W-1:0]  cnt_q  [NUM_CH];
   logic [4:0]        mode_q [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_cfg;
      logic hit_upd;
      assign hit_cfg = cfg_we && (cfg_ch == CH_W'(c));
      assign hit_upd = upd_en && (upd_ch == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_q[c]  <= '0;
            dst_q[c]  <= '0;
            cnt_q[c]  <= '0;
            mode_q[c] <= '0;
         end else begin
            if (hit_upd) begin
               src_q[c] <= upd_src;
               dst_q[c] <= upd_dst;
               cnt_q[c] <= upd_cnt;
            end
            // a register write in the same cycle takes precedence
            if (hit_cfg) begin
               case (cfg_sel_e'(cfg_sel))
                  SEL_SRC:  src_q[c]  <= cfg_wdata;
                  SEL_DST:  dst_q[c]  <= cfg_wdata;
                  SEL_CNT:  cnt_q[c]  <= cfg_wdata[CNT_W-1:0];
                  SEL_MODE: mode_q[c] <= cfg_wdata[4:0];
                  default:  ;
               endcase
            end
         end
      end
   end

   assign rd_src  = src_q[rd_ch];
   assign rd_dst  = dst_q[rd_ch];
   assign rd_cnt  = cnt_q[rd_ch];
   assign rd_mode = mode_q[rd_ch];

endmodule

// File: rtl/dma_pend_arb.sv
module dma_pend_arb #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] trig,
   input  logic              take,
   output logic              grant_vld,
   output logic [CH_W-1:0]   grant_ch
);

   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] clr;

   always_comb begin
      grant_vld = |pend_q;
      grant_ch  = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend_q[i]) grant_ch = CH_W'(i);
      end
   end

   always_comb begin
      clr = '0;
      if (take) clr[grant_ch] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | trig;
   end

   // R11: a start is only taken from a held request
   assert_take_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend_q[grant_ch]);

   // R11: no lower-numbered request is passed over
   assert_lowest_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((pend_q & ((NUM_CH'(1) << grant_ch) - NUM_CH'(1))) == '0));

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_eng_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic [4:0]        mode,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   output logic [ADDR_W-1:0] nx_src,
   output logic [ADDR_W-1:0] nx_dst
);

   logic [ADDR_W-1:0] stride;

   assign stride = {{(ADDR_W-3){1'b0}}, size_bytes(mode[1:0])};

   always_comb begin
      nx_src = src;
      nx_dst = dst;
      case (xfer_mode_e'(mode[4:2]))
         M_DST_UP:  nx_dst = dst + stride;
         M_DST_DN:  nx_dst = dst - stride;
         M_SRC_UP:  nx_src = src + stride;
         M_SRC_DN:  nx_src = src - stride;
         M_BOTH_UP: begin
            nx_src = src + stride;
            nx_dst = dst + stride;
         end
         M_BOTH_DN: begin
            nx_src = src - stride;
            nx_dst = dst - stride;
         end
         M_HOLD:    ;
         M_TALLY:   nx_src = src + ADDR_W'(1);
         default:   ;
      endcase
   end

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
   import dma_eng_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_vld,
   input  logic [CH_W-1:0]   grant_ch,
   input  logic [ADDR_W-1:0] ch_src,
   input  logic [ADDR_W-1:0] ch_dst,
   input  logic [CNT_W-1:0]  ch_cnt,
   input  logic [4:0]        ch_mode,
   input  logic [ADDR_W-1:0] nx_src,
   input  logic [ADDR_W-1:0] nx_dst,
   output logic [4:0]        act_mode,
   output logic [ADDR_W-1:0] act_src,
   output logic [ADDR_W-1:0] act_dst,
   output logic              take,
   output logic              upd_en,
   output logic [CH_W-1:0]   upd_ch,
   output logic [ADDR_W-1:0] upd_src,
   output logic [ADDR_W-1:0] upd_dst,
   output logic [CNT_W-1:0]  upd_cnt,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic [NUM_CH-1:0] tc_irq,
   output logic              err
);

   localparam int STEP_W = $clog2(LEN_LONG);
   localparam int NBYTE  = DATA_W / 8;

   typedef enum logic {S_IDLE, S_RUN} seq_st_e;

   seq_st_e           st_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] last_q;
   logic [CH_W-1:0]   w_ch;
   logic [ADDR_W-1:0] w_src;
   logic [ADDR_W-1:0] w_dst;
   logic [CNT_W-1:0]  w_cnt;
   logic [4:0]        w_mode;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] byte_mask;
   logic              tally;
   logic              at_last;

   assign tally   = (w_mode[4:2] == 3'(M_TALLY));
   assign busy    = (st_q == S_RUN);
   assign take    = (st_q == S_IDLE) && grant_vld;
   assign at_last = busy && (step_q == last_q);

   assign mem_rd    = busy && !tally && (step_q == STEP_W'(PH_READ));
   assign mem_wr    = busy && !tally && (step_q == STEP_W'(PH_WRITE));
   assign mem_addr  = (step_q == STEP_W'(PH_READ)) ? w_src : w_dst;
   assign mem_size  = w_mode[1:0];
   assign mem_wdata = data_q;

   assign act_mode = w_mode;
   assign act_src  = w_src;
   assign act_dst  = w_dst;

   assign upd_en  = at_last;
   assign upd_ch  = w_ch;
   assign upd_src = nx_src;
   assign upd_dst = nx_dst;
   assign upd_cnt = w_cnt - CNT_W'(1);

   always_comb begin
      for (int b = 0; b < NBYTE; b++) begin
         byte_mask[8*b +: 8] = (b < int'(size_bytes(w_mode[1:0]))) ? 8'hFF : 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         step_q <= '0;
         last_q <= '0;
         w_ch   <= '0;
         w_src  <= '0;
         w_dst  <= '0;
         w_cnt  <= '0;
         w_mode <= '0;
         data_q <= '0;
         tc_irq <= '0;
         err    <= 1'b0;
      end else begin
         tc_irq <= '0;
         err    <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (take) begin
                  if (mode_ok(ch_mode)) begin
                     st_q   <= S_RUN;
                     step_q <= '0;
                     last_q <= is_long(ch_mode) ? STEP_W'(LEN_LONG - 1) : STEP_W'(LEN_SHORT - 1);
                     w_ch   <= grant_ch;
                     w_src  <= ch_src;
                     w_dst  <= ch_dst;
                     w_cnt  <= ch_cnt;
                     w_mode <= ch_mode;
                  end else begin
                     err <= 1'b1;
                  end
               end
            end
            default: begin
               if (step_q == STEP_W'(PH_LATCH)) data_q <= mem_rdata & byte_mask;
               if (at_last) begin
                  st_q <= S_IDLE;
                  if (upd_cnt == '0) tc_irq <= NUM_CH'(1) << w_ch;
               end else begin
                  step_q <= step_q + STEP_W'(1);
               end
            end
         endcase
      end
   end

   // ---------------- checks ----------------
   logic [STEP_W:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < (STEP_W+1)'(LEN_LONG)));

   assert_busy_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(run_len) >= (STEP_W+1)'(LEN_SHORT - 1)));

   assert_rd_wr_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_tc_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_irq) |-> $fell(busy));

   assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tc_irq));

   assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy);

   assert_tally_nobus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tally) |-> (!mem_rd && !mem_wr));

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CH_W-1:0]   cfg_ch,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [NUM_CH-1:0] trig,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic [NUM_CH-1:0] tc_irq,
   output logic              err
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and ADDR_W");
   end
   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes, at least 32");
   end

   logic              grant_vld;
   logic [CH_W-1:0]   grant_ch;
   logic              take;
   logic [ADDR_W-1:0] ch_src;
   logic [ADDR_W-1:0] ch_dst;
   logic [CNT_W-1:0]  ch_cnt;
   logic [4:0]        ch_mode;
   logic [4:0]        act_mode;
   logic [ADDR_W-1:0] act_src;
   logic [ADDR_W-1:0] act_dst;
   logic [ADDR_W-1:0] nx_src;
   logic [ADDR_W-1:0] nx_dst;
   logic              upd_en;
   logic [CH_W-1:0]   upd_ch;
   logic [ADDR_W-1:0] upd_src;
   logic [ADDR_W-1:0] upd_dst;
   logic [CNT_W-1:0]  upd_cnt;

   dma_pend_arb #(.NUM_CH(NUM_CH)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .take      (take),
      .grant_vld (grant_vld),
      .grant_ch  (grant_ch)
   );

   dma_chan_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_ch    (cfg_ch),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .upd_en    (upd_en),
      .upd_ch    (upd_ch),
      .upd_src   (upd_src),
      .upd_dst   (upd_dst),
      .upd_cnt   (upd_cnt),
      .rd_ch     (grant_ch),
      .rd_src    (ch_src),
      .rd_dst    (ch_dst),
      .rd_cnt    (ch_cnt),
      .rd_mode   (ch_mode)
   );

   dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .mode   (act_mode),
      .src    (act_src),
      .dst    (act_dst),
      .nx_src (nx_src),
      .nx_dst (nx_dst)
   );

   dma_sequencer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_vld (grant_vld),
      .grant_ch  (grant_ch),
      .ch_src    (ch_src),
      .ch_dst    (ch_dst),
      .ch_cnt    (ch_cnt),
      .ch_mode   (ch_mode),
      .nx_src    (nx_src),
      .nx_dst    (nx_dst),
      .act_mode  (act_mode),
      .act_src   (act_src),
      .act_dst   (act_dst),
      .take      (take),
      .upd_en    (upd_en),
      .upd_ch    (upd_ch),
      .upd_src   (upd_src),
      .upd_dst   (upd_dst),
      .upd_cnt   (upd_cnt),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .tc_irq    (tc_irq),
      .err       (err)
   );

endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;

   localparam int NUM_CH = 8;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 32;
   localparam time TCK   = 20ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_ch = '0;
   logic [1:0]        cfg_sel = '0;
   logic [ADDR_W-1:0] cfg_wdata = '0;
   logic [NUM_CH-1:0] trig = '0;
   logic              mem_rd, mem_wr;
   logic [ADDR_W-1:0] mem_addr;
   logic [1:0]        mem_size;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata;
   logic              busy;
   logic [NUM_CH-1:0] tc_irq;
   logic              err;

   always #(TCK/2) clk = ~clk;

   dma_xfer_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .trig(trig), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .tc_irq(tc_irq), .err(err)
   );

   // byte-wide memory model, read data one cycle after the strobe
   logic [7:0] mem [256];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
         mem_rdata <= '0;
      end else begin
         if (mem_rd)
            mem_rdata <= {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                          mem[8'(mem_addr + 1)], mem[mem_addr[7:0]]};
         if (mem_wr) begin
            for (int i = 0; i < 4; i++)
               if (i < nb(mem_size)) mem[8'(mem_addr + i)] <= mem_wdata[8*i +: 8];
         end
      end
   end

   int n_chk = 0;
   int n_bad = 0;

   function automatic int nb(input logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
   endfunction

   function automatic logic [31:0] exp_word(input int a, input logic [1:0] sz);
      logic [31:0] w = '0;
      for (int i = 0; i < nb(sz); i++) w[8*i +: 8] = mem[8'(a + i)];
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg(input int ch, input int sel, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = ADDR_W'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input int ch, input int md, input int s, input int d, input int c);
      cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, c); cfg(ch, 3, md);
   endtask

   // results of one step
   int          r_len, r_rd_at, r_wr_at;
   logic [23:0] r_ra, r_wa;
   logic [31:0] r_wd;
   logic [1:0]  r_ws;
   bit          r_rd, r_wr, r_tc, r_err;

   task automatic run_step(input int ch);
      bit started, done;
      r_len = 0; r_rd_at = 0; r_wr_at = 0; r_ra = '0; r_wa = '0; r_wd = '0; r_ws = '0;
      r_rd = 0; r_wr = 0; r_tc = 0; r_err = 0; started = 0; done = 0;
      @(negedge clk); trig = NUM_CH'(1) << ch;
      @(negedge clk); trig = '0;
      for (int i = 0; i < 20 && !done; i++) begin
         @(negedge clk);
         if (err) r_err = 1;
         if (busy) begin started = 1; r_len++; end
         if (mem_rd) begin r_rd = 1; r_ra = mem_addr; r_rd_at = r_len; end
         if (mem_wr) begin r_wr = 1; r_wa = mem_addr; r_wd = mem_wdata; r_ws = mem_size; r_wr_at = r_len; end
         if (!busy && started) begin r_tc = tc_irq[ch]; done = 1; end
         else if (!busy && i >= 4) done = 1;
      end
   endtask

   function automatic string tag(input logic [4:0] m);
      case (m[4:2])
         3'd0, 3'd1: return "R2";
         3'd2, 3'd3: return "R3";
         3'd4, 3'd5: return "R4";
         default:    return "R5";
      endcase
   endfunction

   typedef struct packed {
      logic [2:0]        ch;
      logic [4:0]        mode;
      logic [7:0]        src;
      logic [7:0]        dst;
      logic [7:0]        cnt;
      logic signed [7:0] sd;
      logic signed [7:0] dd;
      logic [3:0]        len;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{3'd0, 5'b000_00, 8'h10, 8'h40, 8'd2,  8'sd0,  8'sd1, 4'd5},
      '{3'd1, 5'b001_01, 8'h12, 8'h80, 8'd3,  8'sd0, -8'sd2, 4'd5},
      '{3'd2, 5'b010_10, 8'h20, 8'h90, 8'd2,  8'sd4,  8'sd0, 4'd5},
      '{3'd3, 5'b011_00, 8'h30, 8'hA0, 8'd2, -8'sd1,  8'sd0, 4'd5},
      '{3'd4, 5'b100_01, 8'h50, 8'hB0, 8'd2,  8'sd2,  8'sd2, 4'd6},
      '{3'd5, 5'b101_10, 8'h60, 8'hC0, 8'd2, -8'sd4, -8'sd4, 4'd6},
      '{3'd6, 5'b110_01, 8'h70, 8'hD0, 8'd2,  8'sd0,  8'sd0, 4'd5},
      '{3'd7, 5'b100_10, 8'h04, 8'hE0, 8'd3,  8'sd4,  8'sd4, 4'd6}
   };

   // monitor for the pending-order test
   bit          log_en = 0;
   int          log_n = 0;
   int          starts = 0;
   logic [23:0] log_a [8];
   bit          prev_busy = 0;
   always @(negedge clk) begin
      if (log_en) begin
         if (busy && !prev_busy) starts++;
         if (mem_rd && log_n < 8) begin log_a[log_n] = mem_addr; log_n++; end
      end
      prev_busy = busy;
   end

   initial begin
      #(TCK * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] ew;
      repeat (3) @(negedge clk);
      // R1: idle outputs straight after reset
      check(!busy && !err && tc_irq == 0 && !mem_rd && !mem_wr, "R1", "reset outputs",
            {busy, err, mem_rd, mem_wr, tc_irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !mem_rd && !mem_wr, "R1", "idle after reset", {busy, mem_rd, mem_wr}, 0);

      // table of modes and sizes
      foreach (VEC[k]) begin
         vec_t v;
         v = VEC[k];
         setup(v.ch, v.mode, v.src, v.dst, v.cnt);
         ew = exp_word(v.src, v.mode[1:0]);
         run_step(v.ch);
         check(r_len == int'(v.len), "R9", "busy length", r_len, v.len);
         check(r_rd && r_rd_at == 2, "R12", "read cycle", r_rd_at, 2);
         check(r_ra == 24'(v.src), tag(v.mode), "first read address", r_ra, v.src);
         check(r_wr && r_wr_at == 4, "R12", "write cycle", r_wr_at, 4);
         check(r_wa == 24'(v.dst), tag(v.mode), "first write address", r_wa, v.dst);
         check(r_wd == ew, "R7", "write data bytes", r_wd, ew);
         check(r_ws == v.mode[1:0], "R7", "mem_size code", r_ws, v.mode[1:0]);
         check(!r_tc, "R8", "no terminal count yet", r_tc, 0);
         run_step(v.ch);
         check(r_ra == 24'(int'(v.src) + int'(v.sd)), tag(v.mode), "stepped read address",
               r_ra, int'(v.src) + int'(v.sd));
         check(r_wa == 24'(int'(v.dst) + int'(v.dd)), tag(v.mode), "stepped write address",
               r_wa, int'(v.dst) + int'(v.dd));
         check(r_tc == (v.cnt == 2), "R8", "terminal count on second step", r_tc, v.cnt == 2);
      end

      // R6 counter mode, R13 reprogramming of mode and count
      setup(0, 5'b111_00, 'h33, 'h44, 2);
      run_step(0);
      check(!r_rd && !r_wr, "R6", "counter step bus idle", {r_rd, r_wr}, 0);
      check(r_len == 5, "R9", "counter step length", r_len, 5);
      check(!r_tc, "R6", "counter first step no tc", r_tc, 0);
      run_step(0);
      check(r_tc, "R6", "counter reaches zero", r_tc, 1);
      cfg(0, 3, 5'b010_00);
      cfg(0, 2, 5);
      run_step(0);
      check(r_ra == 24'h35, "R6", "source after two counter steps", r_ra, 'h35);
      check(r_wa == 24'h44 && !r_tc, "R13", "reprogrammed mode and count", r_wa, 'h44);

      // R8 count of one ends on first step
      setup(3, 5'b110_00, 'h08, 'h09, 1);
      run_step(3);
      check(r_tc, "R8", "count of one", r_tc, 1);

      // R10 refused mode words
      setup(1, 5'b000_11, 'h10, 'h88, 1);
      run_step(1);
      check(r_err && r_len == 0, "R10", "size 11 refused", {r_err, 4'(r_len)}, 'h10);
      check(!r_rd && !r_wr && !r_tc, "R10", "size 11 no bus", {r_rd, r_wr, r_tc}, 0);
      cfg(1, 3, 5'b111_10);
      run_step(1);
      check(r_err && r_len == 0 && !r_rd, "R10", "counter with size 10 refused",
            {r_err, 4'(r_len)}, 'h10);
      cfg(1, 3, 5'b000_00);
      run_step(1);
      check(!r_err && r_ra == 24'h10 && r_wa == 24'h88, "R10", "registers untouched",
            r_wa, 'h88);
      check(r_tc, "R10", "count untouched", r_tc, 1);

      // R11 pending requests, lowest first, merged repeats
      setup(6, 5'b110_00, 'h16, 'h26, 9);
      setup(5, 5'b110_00, 'h15, 'h25, 9);
      setup(2, 5'b110_00, 'h12, 'h22, 9);
      log_n = 0; starts = 0; log_en = 1;
      @(negedge clk); trig = 8'h40;
      @(negedge clk); trig = 8'h00;
      @(negedge clk); trig = 8'h24;
      @(negedge clk); trig = 8'h04;
      @(negedge clk); trig = 8'h00;
      repeat (40) @(negedge clk);
      log_en = 0;
      check(starts == 3 && log_n == 3, "R11", "three steps, repeat merged", starts, 3);
      check(log_a[0] == 24'h16, "R11", "running channel first", log_a[0], 'h16);
      check(log_a[1] == 24'h12, "R11", "lowest pending next", log_a[1], 'h12);
      check(log_a[2] == 24'h15, "R11", "higher pending last", log_a[2], 'h15);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule